// File: doc/BRIEF.md
# FP8U Two-Product Blend Multiply-Add

This block is the arithmetic core of a rasterizer's blend stage. Each cycle it may accept four operands: a source value, a source factor, a destination value and a destination factor. It returns `src_val*src_fac + dst_val*dst_fac` as an 8-bit unsigned minifloat. The code has a 4-bit exponent field in bits 7:4 and a 4-bit fraction field in bits 3:0, with an exponent bias of 7. There is no sign bit, and the code has no encoding for infinity or NaN.

Operands arrive in 16-bit fixed-point lanes, and the result leaves the same way. The pipeline has no stalls. An operand set qualified by `in_valid` produces a result qualified by `out_valid` exactly three cycles later.

Both products and their sum are formed exactly, with no bits dropped. A leading-one search then normalizes the exact sum, and the result is rounded once to the nearest representable code, with ties going to the even code. A result that is too large saturates to the largest code.

Top module: `fp8u_blend_mac`

## Requirements
- R1: For an exponent field E (bits 7:4) of 1 to 15 and a fraction field F (bits 3:0), a code has the value (1 + F/16) * 2^(E-7). For example, 0x70 is 1.0, 0x78 is 1.5 and 0x80 is 2.0.
- R2: A code with E = 0 is subnormal, with the value F/16 * 2^-6 and no hidden bit. Code 0x00 is exactly zero.
- R3: A lane whose bit 15 is set (a negative fixed-point word) is treated as the operand 0x00.
- R4: A non-negative lane with any of bits 14:8 set is treated as the operand 0xFF.
- R5: The result is the exact value of A*B + C*D, rounded to the nearest representable code. A tie goes to the code whose bit 0 is 0.
- R6: A sum that rounds above 0xFF (496.0) gives 0xFF.
- R7: A sum of at most half the smallest subnormal step (2^-11) gives 0x00.
- R8: `out_valid` equals `in_valid` delayed by exactly three clock cycles, and the result belongs to the operands sampled in that cycle.
- R9: `out_word` carries the result code in bits 7:0, and bits 15:8 are zero.
- R10: While `rst` is high, `out_valid` and `out_word` clear to zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the four operand lanes |
| src_val | input | 16 | Source value lane (FP8U in bits 7:0) |
| src_fac | input | 16 | Source blend factor lane |
| dst_val | input | 16 | Destination value lane |
| dst_fac | input | 16 | Destination blend factor lane |
| out_valid | output | 1 | Qualifies out_word |
| out_word | output | 16 | Blended result, FP8U zero-extended |

## Verification
Several properties are checked on every cycle. The assertions follow the valid bit through all three pipeline stages. They also confirm that negative lanes decode to zero and oversized lanes decode to the largest code. At the output, they check that a sum above the rounding limit lands on 0xFF and that a sum no larger than half a subnormal step lands on 0x00.

Only the bench can show the rounded value itself, including the tie cases and the subnormal region. It compares every result against an exhaustive nearest-code search over all 256 codes, using random operands and directed corner operands.

// File: rtl/fp8u_blend_pkg.sv
package fp8u_blend_pkg;
    localparam int LANE_W  = 16;
    localparam int EXP_W   = 4;
    localparam int FRC_W   = 4;
    localparam int BIAS    = 7;

    localparam int CODE_W  = EXP_W + FRC_W;
    localparam int MANT_W  = FRC_W + 1;
    localparam int SHF_MAX = (1 << EXP_W) - 2;
    localparam int SHF_W   = $clog2(SHF_MAX + 1);
    localparam int PSH_W   = $clog2(2 * SHF_MAX + 1);
    localparam int PROD_W  = 2 * MANT_W + 2 * SHF_MAX;
    localparam int SUM_W   = PROD_W + 1;
    localparam int POS_W   = $clog2(SUM_W);
    // operand value = mant * 2^shf * 2^-UNIT_SH
    localparam int UNIT_SH = BIAS - 1 + FRC_W;
    // sums with leading one below LOW_P sit on the finest output grid
    localparam int LOW_P   = UNIT_SH + FRC_W;

    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    // smallest exact sum that rounds past the largest code
    localparam longint SAT_SUM  = longint'(2 * ((1 << MANT_W) - 1) + 1) << (SHF_MAX + UNIT_SH - 1);
    // half of the smallest subnormal step, in product units
    localparam longint HALF_LSB = longint'(1) << (UNIT_SH - 1);

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [SHF_W-1:0]  shf;
    } opnd_t;
endpackage

// File: rtl/fp8u_lane_decode.sv
module fp8u_lane_decode
    import fp8u_blend_pkg::*;
(
    input  logic [LANE_W-1:0] lane,
    output opnd_t             opnd
);
    logic [CODE_W-1:0] code;
    logic [EXP_W-1:0]  ex;
    logic [FRC_W-1:0]  fr;

    always_comb begin
        // clamp the fixed-point lane into code range
        if (lane[LANE_W-1])
            code = '0;
        else if (|lane[LANE_W-2:CODE_W])
            code = CODE_MAX;
        else
            code = lane[CODE_W-1:0];
        ex = code[CODE_W-1:FRC_W];
        fr = code[FRC_W-1:0];
        if (ex == '0) begin
            opnd.mant = {1'b0, fr};
            opnd.shf  = '0;
        end else begin
            opnd.mant = {1'b1, fr};
            opnd.shf  = SHF_W'(ex - 1'b1);
        end
    end
endmodule

// File: rtl/fp8u_mul_stage.sv
module fp8u_mul_stage
    import fp8u_blend_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  opnd_t             opa,
    input  opnd_t             opb,
    output logic [PROD_W-1:0] prod
);
    logic [2*MANT_W-1:0] mm;
    logic [PSH_W-1:0]    sh;

    always_comb begin
        mm = (2*MANT_W)'(opa.mant) * (2*MANT_W)'(opb.mant);
        sh = PSH_W'(opa.shf) + PSH_W'(opb.shf);
    end

    always_ff @(posedge clk) begin
        if (rst)
            prod <= '0;
        else
            prod <= PROD_W'(mm) << sh;
    end
endmodule

// File: rtl/fp8u_round_encode.sv
module fp8u_round_encode
    import fp8u_blend_pkg::*;
(
    input  logic [SUM_W-1:0]  sum,
    output logic [CODE_W-1:0] code
);
    logic [POS_W-1:0] lead;
    logic [POS_W-1:0] sh;
    logic [SUM_W-1:0] q;
    logic [SUM_W-1:0] rem;
    logic [SUM_W-1:0] half;
    logic [SUM_W-1:0] n;
    logic [SUM_W-1:0] raw;
    logic             up;

    always_comb begin
        lead = '0;
        for (int i = 0; i < SUM_W; i++)
            if (sum[i]) lead = POS_W'(i);
        // grid step for the binade holding the leading one
        sh   = (lead < POS_W'(LOW_P)) ? POS_W'(UNIT_SH) : lead - POS_W'(FRC_W);
        q    = sum >> sh;
        rem  = sum & ((SUM_W'(1) << sh) - SUM_W'(1));
        half = SUM_W'(1) << (sh - POS_W'(1));
        up   = (rem > half) || ((rem == half) && q[0]);
        n    = q + SUM_W'(up);
        // a carry out of the fraction moves naturally into the exponent
        if (lead < POS_W'(LOW_P))
            raw = n;
        else
            raw = (SUM_W'(lead - POS_W'(LOW_P - 1)) << FRC_W) + n - SUM_W'(1 << FRC_W);
        code = (raw > SUM_W'(CODE_MAX)) ? CODE_MAX : raw[CODE_W-1:0];
    end
endmodule

// File: rtl/fp8u_blend_mac.sv
module fp8u_blend_mac
    import fp8u_blend_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [LANE_W-1:0] src_val,
    input  logic [LANE_W-1:0] src_fac,
    input  logic [LANE_W-1:0] dst_val,
    input  logic [LANE_W-1:0] dst_fac,
    output logic              out_valid,
    output logic [LANE_W-1:0] out_word
);
    localparam int N_OPND = 4;
    localparam int N_PROD = N_OPND / 2;

    logic [LANE_W-1:0] lanes [N_OPND];
    opnd_t             dec   [N_OPND];
    opnd_t             opq   [N_OPND];
    logic [PROD_W-1:0] prod  [N_PROD];
    logic [SUM_W-1:0]  sum;
    logic [CODE_W-1:0] code;
    logic              v1, v2;

    always_comb begin
        lanes[0] = src_val;
        lanes[1] = src_fac;
        lanes[2] = dst_val;
        lanes[3] = dst_fac;
    end

    // stage 1: clamp, decode and capture operands
    for (genvar g = 0; g < N_OPND; g++) begin : g_dec
        fp8u_lane_decode i_dec (.lane(lanes[g]), .opnd(dec[g]));
        always_ff @(posedge clk) begin
            if (rst) opq[g] <= '0;
            else     opq[g] <= dec[g];
        end
    end

    // stage 2: registered products
    for (genvar p = 0; p < N_PROD; p++) begin : g_mul
        fp8u_mul_stage i_mul (
            .clk (clk),
            .rst (rst),
            .opa (opq[2*p]),
            .opb (opq[2*p+1]),
            .prod(prod[p])
        );
    end

    // stage 3: exact sum, round and encode
    assign sum = SUM_W'(prod[0]) + SUM_W'(prod[1]);

    fp8u_round_encode i_enc (.sum(sum), .code(code));

    always_ff @(posedge clk) begin
        if (rst) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            v1        <= in_valid;
            v2        <= v1;
            out_valid <= v2;
            out_word  <= LANE_W'(code);
        end
    end

    // R8
    valid_s1_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (v1 == $past(in_valid)));
    // R8
    valid_s2_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (v2 == $past(v1)));
    // R8
    valid_out_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(v2)));
    // R3
    neg_lane_chk: assert property (@(posedge clk) disable iff (rst)
        src_val[LANE_W-1] |=> (opq[0] == '0));
    // R4
    big_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (!src_fac[LANE_W-1] && (|src_fac[LANE_W-2:CODE_W]))
        |=> (opq[1].mant == '1 && opq[1].shf == SHF_W'(SHF_MAX)));
    // R6
    sat_out_chk: assert property (@(posedge clk) disable iff (rst)
        (64'(sum) >= SAT_SUM) |=> (out_word[CODE_W-1:0] == CODE_MAX));
    // R7
    tiny_out_chk: assert property (@(posedge clk) disable iff (rst)
        (64'(sum) <= HALF_LSB) |=> (out_word == '0));
endmodule

// File: tb/test_fp8u_blend_mac.sv
module test_fp8u_blend_mac;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] src_val = '0, src_fac = '0, dst_val = '0, dst_fac = '0;
    logic        out_valid;
    logic [15:0] out_word;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    hist_v [3];
    int    hist_e [3];
    string hist_t [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    fp8u_blend_mac i_fp8u_blend_mac (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_val(src_val), .src_fac(src_fac), .dst_val(dst_val), .dst_fac(dst_fac),
        .out_valid(out_valid), .out_word(out_word)
    );

    // value in units of 2^-10
    function automatic longint code_val(int c);
        int e = (c >> 4) & 15;
        int f = c & 15;
        if (e == 0) return longint'(f);
        return longint'(16 + f) << (e - 1);
    endfunction

    function automatic int lane_code(logic [15:0] w);
        if (w[15]) return 0;
        if (w[14:8] != 0) return 255;
        return int'(w[7:0]);
    endfunction

    // exhaustive nearest-code search, ties to even code
    function automatic int ref_blend(logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [15:0] d);
        longint s = code_val(lane_code(a)) * code_val(lane_code(b))
                  + code_val(lane_code(c)) * code_val(lane_code(d));
        longint best_d = -1;
        int     best = 0;
        for (int k = 0; k < 256; k++) begin
            longint t  = code_val(k) << 10;
            longint dd = (s > t) ? s - t : t - s;
            if (best_d < 0 || dd < best_d || (dd == best_d && (k % 2) == 0)) begin
                best_d = dd;
                best   = k;
            end
        end
        return best;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [15:0] d, string tag);
        @(negedge clk);
        chk(out_valid == hist_v[2], "R8 out_valid latency", longint'(out_valid), longint'(hist_v[2]));
        if (hist_v[2]) begin
            chk(out_word[7:0] == hist_e[2][7:0], hist_t[2], longint'(out_word[7:0]), longint'(hist_e[2]));
            chk(out_word[15:8] == 8'h00, "R9 upper byte", longint'(out_word[15:8]), 0);
        end
        for (int i = 2; i > 0; i--) begin
            hist_v[i] = hist_v[i-1];
            hist_e[i] = hist_e[i-1];
            hist_t[i] = hist_t[i-1];
        end
        in_valid = v; src_val = a; src_fac = b; dst_val = c; dst_fac = d;
        hist_v[0] = v;
        hist_e[0] = ref_blend(a, b, c, d);
        hist_t[0] = tag;
    endtask

    function automatic logic [15:0] rnd_lane();
        if (($urandom % 8) == 0) return 16'($urandom);
        return {8'h00, 8'($urandom)};
    endfunction

    initial begin
        for (int i = 0; i < 3; i++) begin
            hist_v[i] = 1'b0; hist_e[i] = 0; hist_t[i] = "";
        end
        void'($urandom(32'h00B1E5D0));
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(out_valid == 1'b0, "R10 reset out_valid", longint'(out_valid), 0);
        chk(out_word == 16'h0000, "R10 reset out_word", longint'(out_word), 0);
        rst = 1'b0;

        step(1, 16'h0070, 16'h0070, 16'h0000, 16'h0000, "R1 1.0*1.0");
        step(1, 16'h0078, 16'h0080, 16'h0000, 16'h0000, "R1 1.5*2.0");
        step(1, 16'h0000, 16'h007F, 16'h0070, 16'h0078, "R2 zero operand");
        step(1, 16'h0008, 16'h0080, 16'h0000, 16'h0000, "R2 subnormal");
        step(1, 16'h0070, 16'h0070, 16'h0070, 16'h0020, "R5 tie to even low");
        step(1, 16'h0071, 16'h0070, 16'h0070, 16'h0020, "R5 tie to even high");
        step(0, 16'h0055, 16'h0066, 16'h0077, 16'h0011, "R8 idle");
        step(1, 16'h00FF, 16'h00FF, 16'h00FF, 16'h00FF, "R6 saturate max");
        step(1, 16'h00FF, 16'h0080, 16'h0000, 16'h0000, "R6 saturate 992");
        step(1, 16'h00FF, 16'h0070, 16'h0001, 16'h0001, "R6 max plus tiny");
        step(1, 16'h0001, 16'h0001, 16'h0001, 16'h0001, "R7 tiny sum");
        step(1, 16'h0020, 16'h0010, 16'h0000, 16'h0000, "R7 exact half step");
        step(1, 16'h0020, 16'h0011, 16'h0000, 16'h0000, "R7 just above half");
        step(1, 16'h8070, 16'h0070, 16'h0070, 16'h0070, "R3 negative source");
        step(1, 16'h0070, 16'h0070, 16'hFFFF, 16'h0070, "R3 negative dest");
        step(1, 16'h0100, 16'h0070, 16'h0000, 16'h0000, "R4 large lane");
        step(1, 16'h0030, 16'h7F00, 16'h0000, 16'h0000, "R4 large factor");

        for (int n = 0; n < 3000; n++)
            step(($urandom % 4) != 0, rnd_lane(), rnd_lane(), rnd_lane(), rnd_lane(), "R5 random");

        for (int n = 0; n < 4; n++)
            step(0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, "R8 flush");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule